// File: doc/BRIEF.md
# Bus Wait-State Counter

This block stretches CPU bus cycles. When the address decoder finishes decoding an access, it strobes a load with a wait class and, for one class, an explicit count. The block turns that class into a number of wait ticks and holds the CPU ready line low until that many ticks of a separate tick enable have passed.

The wait class sets the count:
- Plain register accesses take one tick.
- Memory and expansion-bus accesses take one tick, or none when turbo is on.
- Video accesses take one tick, or a longer fixed count when video waits are enabled. A read and a write use different long counts.
- Sound-chip accesses take a long fixed count.

A load that belongs to a debug access is dropped completely, so a debugger can look at the bus without disturbing timing. A new load always replaces whatever count is still pending.

Top module: `wait_state_gen`

## Requirements
- R1: After reset, `rdy` is high and no wait is pending.
- R2: A load with class 0 (none), class 7 (reserved) or class 6 (explicit) with `ld_count` = 0 leaves `rdy` high.
- R3: A load with class 1 (register) holds `rdy` low for exactly 1 tick.
- R4: A load with class 3 (video read) holds `rdy` low for 16 ticks when `vid_wait_en` is 1, and for 1 tick when it is 0.
- R5: A load with class 4 (video write) holds `rdy` low for 17 ticks when `vid_wait_en` is 1, and for 1 tick when it is 0.
- R6: A load with class 5 (sound) holds `rdy` low for 24 ticks, whether or not turbo is on.
- R7: A load with class 2 (memory or expansion bus) holds `rdy` low for 1 tick when `turbo` is 0. It leaves `rdy` high when `turbo` is 1.
- R8: A load with class 6 (explicit) holds `rdy` low for `ld_count` ticks, and turbo does not change this.
- R9: A load with `ld_dbg` = 1 changes nothing. A pending count keeps counting, and an idle counter stays ready.
- R10: A new load replaces any count still pending. The new count takes effect at once, and the load wins over a tick in the same cycle.
- R11: The count drops by one on each clock with `tick` high. It holds while `tick` is low. `rdy` rises on the tick edge where the count reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Wait-tick enable; one tick per clock it is high |
| ld | input | 1 | Load strobe from the address decoder |
| ld_dbg | input | 1 | Marks the load as a debug access (ignored) |
| ld_class | input | 3 | Wait class of the access (codes in R2 to R8) |
| ld_count | input | 5 | Explicit tick count for class 6 |
| turbo | input | 1 | Turbo mode: removes memory-class waits |
| vid_wait_en | input | 1 | Enables the long video wait counts |
| rdy | output | 1 | CPU ready; low while a wait is pending |

## Verification
The bound checker checks the counter's stepping rules on every cycle:
- it holds without a tick;
- it drops by one with a tick;
- a debug load leaves it alone;
- the fixed loads for no-wait, register, sound and turbo memory give the right value.

The exact length of each wait, seen at `rdy`, comes only from the bench's scenarios. So does the behaviour of video loads, which depends on `vid_wait_en`. The bench also covers the mid-wait replacement and debug-during-wait cases. These are compared cycle by cycle against a behavioural model.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  typedef enum logic [2:0] {
    WC_NONE = 3'd0,
    WC_REG  = 3'd1,
    WC_MEM  = 3'd2,
    WC_VRD  = 3'd3,
    WC_VWR  = 3'd4,
    WC_SND  = 3'd5,
    WC_EXPL = 3'd6,
    WC_RSVD = 3'd7
  } wait_class_e;
endpackage

// File: rtl/wsg_rst_sync.sv
module wsg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wsg_sel.sv
module wsg_sel
  import wsg_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int BASE_N = 1,
  parameter int VRD_N  = 16,
  parameter int VWR_N  = 17,
  parameter int SND_N  = 24
) (
  input  logic [2:0]       cls,
  input  logic [CNT_W-1:0] expl_count,
  input  logic             turbo,
  input  logic             vid_wait_en,
  output logic [CNT_W-1:0] wait_val
);
  localparam logic [CNT_W-1:0] BASE_V = CNT_W'(BASE_N);
  localparam logic [CNT_W-1:0] VRD_V  = CNT_W'(VRD_N);
  localparam logic [CNT_W-1:0] VWR_V  = CNT_W'(VWR_N);
  localparam logic [CNT_W-1:0] SND_V  = CNT_W'(SND_N);

  wait_class_e cls_e;
  assign cls_e = wait_class_e'(cls);

  always_comb begin
    wait_val = '0;
    unique case (cls_e)
      WC_NONE: wait_val = '0;
      WC_REG:  wait_val = BASE_V;
      WC_MEM:  wait_val = turbo ? '0 : BASE_V;
      WC_VRD:  wait_val = vid_wait_en ? VRD_V : BASE_V;
      WC_VWR:  wait_val = vid_wait_en ? VWR_V : BASE_V;
      WC_SND:  wait_val = SND_V;
      WC_EXPL: wait_val = expl_count;
      WC_RSVD: wait_val = '0;
      default: wait_val = '0;
    endcase
  end
endmodule

// File: rtl/wsg_cnt.sv
module wsg_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ready
);
  logic [CNT_W-1:0] cnt_d;
  logic             busy;
  logic             cnt_en;

  assign busy   = |cnt_q;
  assign cnt_en = load_en | (tick & busy);

  always_comb begin
    cnt_d = cnt_q;
    if (load_en)           cnt_d = load_val;
    else if (tick && busy) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready = ~busy;
endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen #(
  parameter int CNT_W       = 5,
  parameter int BASE_N      = 1,
  parameter int VRD_N       = 16,
  parameter int VWR_N       = 17,
  parameter int SND_N       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ld,
  input  logic             ld_dbg,
  input  logic [2:0]       ld_class,
  input  logic [CNT_W-1:0] ld_count,
  input  logic             turbo,
  input  logic             vid_wait_en,
  output logic             rdy
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] wait_val;
  logic [CNT_W-1:0] cnt_q;
  logic             load_en;

  wsg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wsg_sel #(
    .CNT_W (CNT_W), .BASE_N(BASE_N), .VRD_N(VRD_N),
    .VWR_N (VWR_N), .SND_N (SND_N)
  ) u_sel (
    .cls         (ld_class),
    .expl_count  (ld_count),
    .turbo       (turbo),
    .vid_wait_en (vid_wait_en),
    .wait_val    (wait_val)
  );

  // debug decodes never reach the counter
  assign load_en = ld & ~ld_dbg;

  wsg_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (load_en),
    .load_val (wait_val),
    .tick     (tick),
    .cnt_q    (cnt_q),
    .ready    (rdy)
  );
endmodule

// File: rtl/wait_state_chk.sv
module wait_state_chk #(
  parameter int CNT_W = 5,
  parameter int SND_N = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ld,
  input logic             ld_dbg,
  input logic [2:0]       ld_class,
  input logic             turbo,
  input logic [CNT_W-1:0] cnt,
  input logic             rdy
);
  a_r11_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !tick) |=> $stable(cnt));

  a_r11_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && tick && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

  a_r9_dbg_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && ld_dbg && !tick) |=> $stable(cnt));

  a_r2_none_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !ld_dbg && ld_class == 3'd0) |=> rdy);

  a_r6_sound_len: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !ld_dbg && ld_class == 3'd5) |=> (cnt == CNT_W'(SND_N)));

  a_r7_turbo_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !ld_dbg && ld_class == 3'd2 && turbo) |=> rdy);

  a_r10_replace_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !ld_dbg && ld_class == 3'd1) |=> (cnt == CNT_W'(1)));
endmodule

bind wait_state_gen wait_state_chk #(.CNT_W(CNT_W), .SND_N(SND_N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .tick     (tick),
  .ld       (ld),
  .ld_dbg   (ld_dbg),
  .ld_class (ld_class),
  .turbo    (turbo),
  .cnt      (cnt_q),
  .rdy      (rdy)
);

// File: tb/sim_wait_state_gen.sv
`timescale 1ns/1ps
module sim_wait_state_gen;
  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       ld;
  logic       ld_dbg;
  logic [2:0] ld_class;
  logic [4:0] ld_count;
  logic       turbo;
  logic       vid_wait_en;
  logic       rdy;

  int tests  = 0;
  int fails  = 0;
  int model  = 0;
  bit model_on = 0;
  bit done = 0;

  wait_state_gen u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld(ld), .ld_dbg(ld_dbg),
    .ld_class(ld_class), .ld_count(ld_count), .turbo(turbo),
    .vid_wait_en(vid_wait_en), .rdy(rdy)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic int expect_len(int cls, int cnt, bit tb, bit ve);
    case (cls)
      1: return 1;
      2: return tb ? 0 : 1;
      3: return ve ? 16 : 1;
      4: return ve ? 17 : 1;
      5: return 24;
      6: return cnt;
      default: return 0;
    endcase
  endfunction

  // behavioural reference, one update per clock
  always @(posedge clk) begin
    if (!rst_n) model = 0;
    else if (ld && !ld_dbg) model = expect_len(ld_class, ld_count, turbo, vid_wait_en);
    else if (tick && model > 0) model = model - 1;
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      tests++;
      if (rdy !== (model == 0)) begin
        fails++;
        $display("FAIL R11 per-cycle rdy actual=%0b expected=%0b", rdy, model == 0);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(int cls, int cnt, bit dbg);
    ld = 1; ld_class = 3'(cls); ld_count = 5'(cnt); ld_dbg = dbg;
    @(negedge clk);
    ld = 0; ld_dbg = 0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (!rdy && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run(string req, int cls, int cnt, int exp);
    int n;
    access(cls, cnt, 0);
    measure(n);
    check(req, n, exp);
  endtask

  initial begin
    int n;
    rst_n = 0; tick = 1; ld = 0; ld_dbg = 0; ld_class = 0; ld_count = 0;
    turbo = 0; vid_wait_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1", rdy, 1);
    model_on = 1;

    run("R2", 0, 0, 0);
    run("R2", 7, 0, 0);
    run("R2", 6, 0, 0);
    run("R3", 1, 0, 1);
    run("R4", 3, 0, 16);
    run("R5", 4, 0, 17);
    vid_wait_en = 0;
    run("R4", 3, 0, 1);
    run("R5", 4, 0, 1);
    vid_wait_en = 1;
    run("R6", 5, 0, 24);
    run("R7", 2, 0, 1);
    run("R8", 6, 9, 9);
    run("R8", 6, 31, 31);
    turbo = 1;
    run("R7", 2, 0, 0);
    run("R6", 5, 0, 24);
    run("R8", 6, 9, 9);
    turbo = 0;

    // R9: debug load while idle, then during a pending wait
    access(5, 0, 1);
    check("R9", rdy, 1);
    access(6, 5, 0);
    access(5, 0, 1);
    measure(n);
    check("R9", n, 4);

    // R10: replace a long pending wait mid-way
    access(5, 0, 0);
    repeat (3) @(negedge clk);
    access(1, 0, 0);
    measure(n);
    check("R10", n, 1);

    // R11: no tick, count holds
    tick = 0;
    access(6, 3, 0);
    repeat (10) @(negedge clk);
    check("R11", rdy, 0);
    tick = 1;
    measure(n);
    check("R11", n, 3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule